// File: doc/BRIEF.md
# Reloadable Compare Pulse Timer

This block is a single up-counting timer channel with a 24-bit counter by default. When software turns the timer on, the counter is cleared. The first timer tick after that loads a programmed start value. Each later tick adds one. Whenever the count written on a tick equals a programmed compare value, the block does three things:

- it sets a sticky compare flag;
- it drives its output pin to the opposite of the idle level for one tick period;
- in reload mode, it loads the start value again on the following tick.

In reload mode the start value therefore sets both the delay to the first pulse and the spacing between later pulses. When the counter passes its all-ones value, it wraps to zero and sets a sticky overflow flag.

Timer ticks come from one of two sources, chosen by a select bit. One is an internal divide-by-two of the block clock. The other is an external single-cycle tick strobe, for example from a prescaler. Configuration values arrive as plain register ports. The count is always visible on an output, and reading it has no side effect. Each flag is cleared by a one-cycle clear strobe. Each interrupt line is the flag ANDed with its enable.

Top module: `cmp_pulse_timer`

## Requirements
- R1: On the first clock edge with `enable` high after it was low, the count becomes 0. The first timer tick after that writes `load_value` into the count.
- R2: With `tick_sel`=0, a tick occurs on every second clock while enabled, and the first tick falls in the second cycle after enable. With `tick_sel`=1, each cycle with `ext_tick` high is a tick. The unselected source has no effect on the count.
- R3: Every tick after the initial load adds one to `count`, unless a reload is due. `count` always shows the counter value.
- R4: A tick that writes a value equal to `compare_value` into the counter sets `cmp_flag`. This includes a load tick.
- R5: While no match pulse is active, `pulse_out` equals `invert`. After a matching tick, `pulse_out` equals the inverse of `invert` until the next tick. The next tick ends the pulse unless that tick matches again.
- R6: With `reload_en`=1, the tick after a match writes `load_value` into the count. With `reload_en`=0, counting continues past the compare value.
- R7: A tick that increments the all-ones count wraps the count to 0 and sets `ovf_flag`.
- R8: Both flags are sticky until their clear strobe (`cmp_clr` / `ovf_clr`) is high for a cycle. A flag-setting event in the same cycle as the clear wins, and the flag stays set.
- R9: `cmp_irq` is `cmp_flag` AND `cmp_irq_en`. `ovf_irq` is `ovf_flag` AND `ovf_irq_en`.
- R10: With `enable` low, the count holds and ticks are ignored. From the next clock edge on, `pulse_out` equals `invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Timer run control |
| tick_sel | input | 1 | 0: clock divided by two, 1: external tick |
| ext_tick | input | 1 | External tick strobe, one cycle per tick |
| load_value | input | CNT_W | Start / reload value |
| compare_value | input | CNT_W | Match value |
| reload_en | input | 1 | Reload start value on the tick after a match |
| invert | input | 1 | Idle level of the output pin |
| cmp_irq_en | input | 1 | Compare interrupt enable |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| cmp_clr | input | 1 | Clear strobe for the compare flag |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| pulse_out | output | 1 | Output pin |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| count | output | CNT_W | Current counter value |

## Verification
Two cases can fall in the same cycle, and the bench provokes each one.

The first is a compare match and that flag's clear strobe. The bench sets load and compare to the same value with reload on, so that every tick matches. It then raises `cmp_clr` in the cycle of a tick and expects `cmp_flag` still set afterwards. A lone clear must then drop the flag.

The second is a wrap and a match on the same tick. The bench loads the all-ones value with a compare value of zero. It expects both flags set and the pulse active after the wrapping tick.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

    typedef enum logic {
        SRC_DIV2 = 1'b0,
        SRC_EXT  = 1'b1
    } tick_src_e;

    localparam int unsigned NUM_EVT = 2;
    localparam int unsigned EVT_CMP = 0;
    localparam int unsigned EVT_OVF = 1;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

endpackage

// File: rtl/cpt_tick_gen.sv
module cpt_tick_gen
    import cpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick_sel,
    input  logic ext_tick,
    output logic tick
);

    typedef struct packed {
        logic phase;
    } tg_state_t;

    tg_state_t st_d, st_q;
    tick_src_e src;

    always_comb begin
        src      = tick_src_e'(tick_sel);
        st_d     = st_q;
        st_d.phase = enable ? ~st_q.phase : 1'b0;
        unique case (src)
            SRC_DIV2: tick = enable & st_q.phase;
            SRC_EXT:  tick = enable & ext_tick;
            default:  tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the divided source never ticks on two clocks in a row
    assert_div_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick_sel == 1'b0 && tick) |=> !(tick && tick_sel == 1'b0));

endmodule

// File: rtl/cpt_count_core.sv
module cpt_count_core
    import cpt_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_value,
    input  logic [CNT_W-1:0] compare_value,
    input  logic             reload_en,
    output logic [CNT_W-1:0] count,
    output logic             pulse,
    output evt_vec_t         evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             loaded;
        logic             reload_due;
        logic             pulse;
    } core_state_t;

    core_state_t      st_d, st_q;
    logic [CNT_W:0]   inc_w;
    logic             hit;
    logic             wrap;

    always_comb begin
        st_d  = st_q;
        hit   = 1'b0;
        wrap  = 1'b0;
        inc_w = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        st_d.run = enable;
        if (!enable) begin
            st_d.loaded     = 1'b0;
            st_d.reload_due = 1'b0;
            st_d.pulse      = 1'b0;
        end else if (!st_q.run) begin
            st_d.cnt        = '0;
            st_d.loaded     = 1'b0;
            st_d.reload_due = 1'b0;
            st_d.pulse      = 1'b0;
        end else if (tick) begin
            if (!st_q.loaded || st_q.reload_due) begin
                st_d.cnt    = load_value;
                st_d.loaded = 1'b1;
            end else begin
                st_d.cnt = inc_w[CNT_W-1:0];
                wrap     = inc_w[CNT_W];
            end
            hit             = (st_d.cnt == compare_value);
            st_d.pulse      = hit;
            st_d.reload_due = hit & reload_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        count        = st_q.cnt;
        pulse        = st_q.pulse;
        evt          = '0;
        evt[EVT_CMP] = hit;
        evt[EVT_OVF] = wrap;
    end

    // R1: a fresh enable clears the counter
    assert_start_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !st_q.run) |=> (count == '0));

    // R1: the first tick after start loads the start value
    assert_first_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.run && tick && !st_q.loaded) |=> (count == $past(load_value)));

    // R7: a wrap only comes from the all-ones value
    assert_wrap_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (st_q.cnt == CNT_MAX));

    // R10: disabled timer holds its count
    assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(count));

    // R5: a pulse lasts one tick unless that tick matches again
    assert_pulse_one_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && enable && tick && !hit) |=> !pulse);

endmodule

// File: rtl/cpt_flag_unit.sv
module cpt_flag_unit
    import cpt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t evt,
    input  evt_vec_t clr,
    input  evt_vec_t irq_en,
    output evt_vec_t flag,
    output evt_vec_t irq
);

    typedef struct packed {
        evt_vec_t flag;
    } fl_state_t;

    fl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_EVT; i++) begin
            st_d.flag[i] = (st_q.flag[i] & ~clr[i]) | evt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag & irq_en;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_chk
        // R8: a flag stays set until its clear strobe
        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && !clr[g]) |=> flag[g]);
        // R8: an event wins over a simultaneous clear
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> flag[g]);
    end

endmodule

// File: rtl/cmp_pulse_timer.sv
module cmp_pulse_timer
    import cpt_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick_sel,
    input  logic             ext_tick,
    input  logic [CNT_W-1:0] load_value,
    input  logic [CNT_W-1:0] compare_value,
    input  logic             reload_en,
    input  logic             invert,
    input  logic             cmp_irq_en,
    input  logic             ovf_irq_en,
    input  logic             cmp_clr,
    input  logic             ovf_clr,
    output logic             pulse_out,
    output logic             cmp_flag,
    output logic             ovf_flag,
    output logic             cmp_irq,
    output logic             ovf_irq,
    output logic [CNT_W-1:0] count
);

    logic     tick;
    logic     pulse;
    evt_vec_t evt, clr_v, ien_v, flag_v, irq_v;

    cpt_tick_gen u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tick_sel (tick_sel),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    cpt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .tick          (tick),
        .load_value    (load_value),
        .compare_value (compare_value),
        .reload_en     (reload_en),
        .count         (count),
        .pulse         (pulse),
        .evt           (evt)
    );

    always_comb begin
        clr_v          = '0;
        ien_v          = '0;
        clr_v[EVT_CMP] = cmp_clr;
        clr_v[EVT_OVF] = ovf_clr;
        ien_v[EVT_CMP] = cmp_irq_en;
        ien_v[EVT_OVF] = ovf_irq_en;
    end

    cpt_flag_unit u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (clr_v),
        .irq_en (ien_v),
        .flag   (flag_v),
        .irq    (irq_v)
    );

    assign pulse_out = invert ^ pulse;
    assign cmp_flag  = flag_v[EVT_CMP];
    assign ovf_flag  = flag_v[EVT_OVF];
    assign cmp_irq   = irq_v[EVT_CMP];
    assign ovf_irq   = irq_v[EVT_OVF];

    // R10: once disabled, the pin rests at the idle level
    assert_idle_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pulse_out == invert));

    // R9: no interrupt request without its enable
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_irq && !cmp_irq_en) && !(ovf_irq && !ovf_irq_en));

endmodule

// File: tb/cmp_pulse_timer_tb.sv
module cmp_pulse_timer_tb;

    localparam int W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, tick_sel = 1'b1, ext_tick = 1'b0;
    logic [W-1:0] load_value = '0, compare_value = '0;
    logic reload_en = 1'b0, invert = 1'b0;
    logic cmp_irq_en = 1'b0, ovf_irq_en = 1'b0, cmp_clr = 1'b0, ovf_clr = 1'b0;
    logic pulse_out, cmp_flag, ovf_flag, cmp_irq, ovf_irq;
    logic [W-1:0] count;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmp_pulse_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick_sel(tick_sel),
        .ext_tick(ext_tick), .load_value(load_value), .compare_value(compare_value),
        .reload_en(reload_en), .invert(invert), .cmp_irq_en(cmp_irq_en),
        .ovf_irq_en(ovf_irq_en), .cmp_clr(cmp_clr), .ovf_clr(ovf_clr),
        .pulse_out(pulse_out), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
        .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .count(count)
    );

    // load, compare, reload, ticks, exp count, exp cmp flag, exp ovf flag, exp pulse
    localparam int NV = 8;
    localparam logic [83:0] VEC [NV] = '{
        {24'h00000A, 24'h000014, 1'b0, 8'd1,  24'h00000A, 1'b0, 1'b0, 1'b0},
        {24'h00000A, 24'h000014, 1'b0, 8'd11, 24'h000014, 1'b1, 1'b0, 1'b1},
        {24'h00000A, 24'h000014, 1'b1, 8'd12, 24'h00000A, 1'b1, 1'b0, 1'b0},
        {24'h00000A, 24'h000014, 1'b0, 8'd12, 24'h000015, 1'b1, 1'b0, 1'b0},
        {24'hFFFFFE, 24'h000005, 1'b0, 8'd3,  24'h000000, 1'b0, 1'b1, 1'b0},
        {24'hFFFFFF, 24'h000000, 1'b0, 8'd2,  24'h000000, 1'b1, 1'b1, 1'b1},
        {24'h000007, 24'h000007, 1'b1, 8'd1,  24'h000007, 1'b1, 1'b0, 1'b1},
        {24'h000000, 24'h000003, 1'b1, 8'd9,  24'h000000, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_once();
        ext_tick = 1'b1;
        @(negedge clk);
        ext_tick = 1'b0;
    endtask

    task automatic restart(input logic [W-1:0] ld, input logic [W-1:0] cmp,
                           input logic rl, input logic inv);
        @(negedge clk);
        enable = 1'b0; cmp_clr = 1'b1; ovf_clr = 1'b1;
        load_value = ld; compare_value = cmp; reload_en = rl; invert = inv;
        @(negedge clk);
        cmp_clr = 1'b0; ovf_clr = 1'b0; enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        check("R5 reset pin idle", pulse_out, 0);
        check("R3 reset count", count, 0);
        check("R8 reset flags", {cmp_flag, ovf_flag}, 0);
        check("R9 reset irqs", {cmp_irq, ovf_irq}, 0);
        rst_n = 1'b1;
        tick_sel = 1'b1;

        // table of external-tick scenarios (R1 R3 R4 R5 R6 R7)
        for (int i = 0; i < NV; i++) begin
            logic [83:0] v;
            v = VEC[i];
            restart(v[83:60], v[59:36], v[35], i[0]);
            check("R1 cleared on enable", count, 0);
            for (int k = 0; k < int'(v[34:27]); k++) tick_once();
            check("R3 R6 count", count, v[26:3]);
            check("R4 cmp_flag", cmp_flag, v[2]);
            check("R7 ovf_flag", ovf_flag, v[1]);
            check("R5 pulse_out", pulse_out, i[0] ^ v[0]);
        end

        // R8 / R9: match and clear in the same cycle
        restart(24'd5, 24'd5, 1'b1, 1'b0);
        tick_once();
        check("R4 load tick match", cmp_flag, 1);
        cmp_irq_en = 1'b0; #1;
        check("R9 irq masked", cmp_irq, 0);
        cmp_irq_en = 1'b1; #1;
        check("R9 irq raised", cmp_irq, 1);
        cmp_clr = 1'b1;
        tick_once();
        cmp_clr = 1'b0;
        check("R8 set wins over clear", cmp_flag, 1);
        @(negedge clk);
        cmp_clr = 1'b1;
        @(negedge clk);
        cmp_clr = 1'b0;
        check("R8 clear strobe", cmp_flag, 0);
        check("R9 irq follows flag", cmp_irq, 0);
        cmp_irq_en = 1'b0;

        // R9 overflow interrupt
        ovf_irq_en = 1'b1;
        restart(24'hFFFFFF, 24'd5, 1'b0, 1'b0);
        tick_once(); tick_once();
        check("R9 ovf_irq", ovf_irq, 1);
        check("R9 cmp_irq off", cmp_irq, 0);
        ovf_irq_en = 1'b0;

        // R2: divided clock source, external strobe held high and ignored
        @(negedge clk);
        enable = 1'b0; load_value = 24'd100; reload_en = 1'b0;
        compare_value = 24'd50; invert = 1'b0; tick_sel = 1'b0; ext_tick = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        check("R1 R2 clear at start", count, 0);
        @(negedge clk);
        check("R2 first divided tick loads", count, 100);
        @(negedge clk);
        check("R2 no tick on odd clock", count, 100);
        repeat (3) @(negedge clk);
        check("R2 two ticks in four clocks", count, 102);
        ext_tick = 1'b0;

        // R10: disable during a pulse
        tick_sel = 1'b1;
        restart(24'd3, 24'd3, 1'b0, 1'b1);
        tick_once();
        check("R5 pulse inverted", pulse_out, 0);
        enable = 1'b0;
        @(negedge clk);
        check("R10 pin back to idle", pulse_out, 1);
        tick_once(); tick_once();
        check("R10 count held", count, 3);
        check("R10 pin still idle", pulse_out, 1);

        finish_run();
    end

endmodule